// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block runs read bursts on a parallel, asynchronous NOR-style flash that has a 16-bit data bus. Everything in it is clocked by one system clock. A host hands over a word address and a burst length through a valid/ready handshake. The controller then drives the flash address, pulls the chip-select and output-enable strobes low, and holds back each capture until enough clock cycles have passed for every timing limit involved. Each captured word is returned as a one-cycle data pulse, and the final word of the burst carries a last flag.

The flash divides memory into aligned pages of eight words. The page is picked by the upper address bits, and the word within it by the three low bits. Moving to the next word inside the same page costs only the short page-access delay. The first word of a burst pays the full random-access delay, and so does every step that crosses into a new page. When the burst ends, both strobes are released and a bus-release guard keeps them high for a set time. This lets the flash stop driving the data bus before any other transfer begins.

Every limit is set as a nanosecond parameter together with the clock period. Each limit becomes a cycle count: the quotient is rounded up and one margin cycle is added.

Top module: `flash_rd_ctrl`

## Requirements
- R1: During and straight after reset, `fl_ce_n` and `fl_oe_n` are high, `rd_valid` and `rd_last` are low, and `req_ready` is high. A reset that arrives in the middle of a burst releases both strobes and returns no further words.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. At that edge `fl_addr` takes `req_addr`, and `fl_ce_n` and `fl_oe_n` both go low. The first word is captured FIRST_CYC edges later. FIRST_CYC is the largest of the address, chip-select and output-enable limits, each converted to cycles; it is 13 with the default parameters.
- R3: A following word whose address has nonzero low three bits (the same aligned 8-word page) is captured PAGE_CYC edges after the address steps. This is 6 with the defaults.
- R4: A following word whose address has low three bits equal to 000 is a page crossing, and it waits ACC_CYC edges (13 with the defaults). This includes the wrap from the top of the address space back to zero.
- R5: A burst returns `req_len`+1 words from consecutive addresses. Each word is a single-cycle `rd_valid` pulse, and each captured value belongs to the address on the bus at the moment of capture.
- R6: `rd_last` is high together with the final word of a burst and with no other word.
- R7: Both strobes rise on the edge that captures the final word. `fl_ce_n` then stays high for at least HIZ_CYC cycles (4 with the defaults) before it falls again.
- R8: `fl_oe_n` is never low while `fl_ce_n` is high.
- R9: `req_ready` stays low from acceptance until the release guard ends. A request held during that time is taken on the first edge after the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 22 | Word address of the first word |
| req_len | input | 4 | Number of words minus one |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | 16 | Returned word |
| rd_last | output | 1 | Marks the final word of the burst |
| fl_addr | output | 22 | Flash word address |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_dq | input | 16 | Flash data bus |

## Verification
The bench uses the default parameters: an 8 ns clock with limits of 90, 90, 20, 35 and 20 ns. These give 13 cycles for random access, 6 for a page step and 4 for the release guard, so a 90 ns limit, a 35 ns limit and a 20 ns limit each map to a different wait. The 22-bit address makes it possible to test the wrap from the last word to word zero as a page crossing. The 4-bit length allows a 16-word burst that crosses two page boundaries. The flash model puts random garbage on the bus until each limit has passed in real time, so any early capture shows up as wrong data.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
package flash_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RECOV = 2'd2
    } rd_state_e;

    // Round a time limit up to whole clock cycles, then add one margin cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns + 1;
    endfunction

    function automatic int unsigned max2(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_rd_timer.sv
`timescale 1ns/1ps
module flash_rd_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/flash_rd_page_step.sv
`timescale 1ns/1ps
module flash_rd_page_step #(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned PAGE_BITS = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              crossing
);

    assign nxt_addr = cur_addr + 1'b1;

    generate
        if (PAGE_BITS == 0) begin : g_no_page
            assign crossing = 1'b1;
        end else begin : g_page
            assign crossing = (nxt_addr[PAGE_BITS-1:0] == '0);
        end
    endgenerate

endmodule

// File: rtl/flash_rd_ctrl.sv
`timescale 1ns/1ps
module flash_rd_ctrl
    import flash_rd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned LEN_W     = 4,
    parameter int unsigned PAGE_BITS = 3,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_ACC_NS  = 90,
    parameter int unsigned T_CE_NS   = 90,
    parameter int unsigned T_OE_NS   = 20,
    parameter int unsigned T_PAGE_NS = 35,
    parameter int unsigned T_HIZ_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    input  logic [DATA_W-1:0] fl_dq
);

    localparam int unsigned ACC_CYC   = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned CE_CYC    = ns_to_cyc(T_CE_NS, CLK_NS);
    localparam int unsigned OE_CYC    = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int unsigned PAGE_CYC  = ns_to_cyc(T_PAGE_NS, CLK_NS);
    localparam int unsigned HIZ_CYC   = ns_to_cyc(T_HIZ_NS, CLK_NS);
    localparam int unsigned FIRST_CYC = max2(max2(ACC_CYC, CE_CYC), OE_CYC);
    localparam int unsigned MAX_CYC   = max2(max2(FIRST_CYC, PAGE_CYC), HIZ_CYC);
    localparam int unsigned TMR_W     = $clog2(MAX_CYC) + 1;

    localparam logic [TMR_W-1:0] LD_FIRST = TMR_W'(FIRST_CYC - 1);
    localparam logic [TMR_W-1:0] LD_ACC   = TMR_W'(ACC_CYC - 1);
    localparam logic [TMR_W-1:0] LD_PAGE  = TMR_W'(PAGE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_HIZ   = TMR_W'(HIZ_CYC - 1);

    typedef struct packed {
        rd_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic              ce_n;
        logic              oe_n;
        logic              vld;
        logic              last;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t             d, q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic [ADDR_W-1:0] step_addr;
    logic              step_cross;

    flash_rd_timer #(
        .CNT_W (TMR_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    flash_rd_page_step #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) step_i (
        .cur_addr (q.addr),
        .nxt_addr (step_addr),
        .crossing (step_cross)
    );

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        d.last   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state  = ST_WAIT;
                    d.addr   = req_addr;
                    d.remain = req_len;
                    d.ce_n   = 1'b0;
                    d.oe_n   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_FIRST;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    d.vld  = 1'b1;
                    d.data = fl_dq;
                    if (q.remain == '0) begin
                        d.last   = 1'b1;
                        d.ce_n   = 1'b1;
                        d.oe_n   = 1'b1;
                        d.state  = ST_RECOV;
                        tmr_load = 1'b1;
                        tmr_val  = LD_HIZ;
                    end else begin
                        d.remain = q.remain - 1'b1;
                        d.addr   = step_addr;
                        tmr_load = 1'b1;
                        tmr_val  = step_cross ? LD_ACC : LD_PAGE;
                    end
                end
            end
            ST_RECOV: begin
                if (tmr_done) begin
                    d.state = ST_IDLE;
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.ce_n  = 1'b1;
                d.oe_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.addr   <= '0;
            q.remain <= '0;
            q.ce_n   <= 1'b1;
            q.oe_n   <= 1'b1;
            q.vld    <= 1'b0;
            q.last   <= 1'b0;
            q.data   <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == ST_IDLE);
    assign rd_valid  = q.vld;
    assign rd_last   = q.last;
    assign rd_data   = q.data;
    assign fl_addr   = q.addr;
    assign fl_ce_n   = q.ce_n;
    assign fl_oe_n   = q.oe_n;

endmodule

// File: rtl/flash_rd_ctrl_chk.sv
`timescale 1ns/1ps
module flash_rd_ctrl_chk
    import flash_rd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned PAGE_BITS = 3,
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned T_ACC_NS  = 90,
    parameter int unsigned T_CE_NS   = 90,
    parameter int unsigned T_OE_NS   = 20,
    parameter int unsigned T_PAGE_NS = 35,
    parameter int unsigned T_HIZ_NS  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              rd_last,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              fl_ce_n,
    input logic              fl_oe_n
);

    localparam int unsigned ACC_CYC   = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned PAGE_CYC  = ns_to_cyc(T_PAGE_NS, CLK_NS);
    localparam int unsigned HIZ_CYC   = ns_to_cyc(T_HIZ_NS, CLK_NS);
    localparam int unsigned FIRST_CYC = max2(max2(ACC_CYC, ns_to_cyc(T_CE_NS, CLK_NS)),
                                             ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int unsigned MAX_CYC   = max2(max2(FIRST_CYC, PAGE_CYC), HIZ_CYC);
    localparam int unsigned AGE_W     = $clog2(MAX_CYC + 2) + 1;
    localparam logic [AGE_W-1:0] AGE_SAT = '1;

    logic [ADDR_W-1:0] prev_addr_q;
    logic              prev_ce_q;
    logic [AGE_W-1:0]  addr_age_q, ce_age_q, hi_age_q;
    logic              addr_chg, ce_fall, ce_rise;

    assign addr_chg = (fl_addr != prev_addr_q);
    assign ce_fall  = !fl_ce_n && prev_ce_q;
    assign ce_rise  = fl_ce_n && !prev_ce_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr_q <= '0;
            prev_ce_q   <= 1'b1;
            addr_age_q  <= '0;
            ce_age_q    <= '0;
            hi_age_q    <= AGE_SAT;
        end else begin
            prev_addr_q <= fl_addr;
            prev_ce_q   <= fl_ce_n;
            addr_age_q  <= (addr_chg || ce_fall) ? AGE_W'(1)
                         : ((addr_age_q == AGE_SAT) ? AGE_SAT : addr_age_q + 1'b1);
            ce_age_q    <= ce_fall ? AGE_W'(1)
                         : ((ce_age_q == AGE_SAT) ? AGE_SAT : ce_age_q + 1'b1);
            hi_age_q    <= ce_rise ? AGE_W'(1)
                         : ((hi_age_q == AGE_SAT) ? AGE_SAT : hi_age_q + 1'b1);
        end
    end

    p_first_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (ce_age_q >= AGE_W'(FIRST_CYC)));

    p_page_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (addr_age_q >= AGE_W'(PAGE_CYC)));

    p_cross_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (prev_addr_q[PAGE_BITS-1:0] == '0)) |-> (addr_age_q >= AGE_W'(ACC_CYC)));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_last_with_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);

    p_release_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_ce_n) |-> (hi_age_q >= AGE_W'(HIZ_CYC)));

    p_oe_inside_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_ce_n);

    p_ready_bus_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_oe_n));

endmodule

bind flash_rd_ctrl flash_rd_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .CLK_NS    (CLK_NS),
    .T_ACC_NS  (T_ACC_NS),
    .T_CE_NS   (T_CE_NS),
    .T_OE_NS   (T_OE_NS),
    .T_PAGE_NS (T_PAGE_NS),
    .T_HIZ_NS  (T_HIZ_NS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_last   (rd_last),
    .fl_addr   (fl_addr),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n)
);

// File: tb/flash_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_rd_ctrl_tb_top;

    localparam int unsigned AW = 22;
    localparam int unsigned DW = 16;
    localparam int unsigned LW = 4;
    localparam int unsigned ACC_C   = 13;
    localparam int unsigned PAGE_C  = 6;
    localparam int unsigned FIRST_C = 13;
    localparam int unsigned HIZ_C   = 4;
    localparam int unsigned NVEC    = 6;

    // vector: {start address, length-1, expected page crossings}
    localparam logic [AW+LW+2-1:0] VEC [NVEC] = '{
        {22'h000010, 4'd0,  2'd0},
        {22'h000020, 4'd7,  2'd0},
        {22'h000035, 4'd5,  2'd1},
        {22'h3FFFFE, 4'd3,  2'd1},
        {22'h000107, 4'd15, 2'd2},
        {22'h0000F3, 4'd2,  2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          rd_valid, rd_last;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] fl_addr;
    logic          fl_ce_n, fl_oe_n;
    logic [DW-1:0] dq = '0;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    int unsigned cyc     = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_rd_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_last   (rd_last),
        .fl_addr   (fl_addr),
        .fl_ce_n   (fl_ce_n),
        .fl_oe_n   (fl_oe_n),
        .fl_dq     (dq)
    );

    function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h3C5A ^ {a[21:16], a[21:12]};
    endfunction

    // Flash model: random garbage until every limit has elapsed in real time.
    logic [AW-1:0] m_addr = '0;
    logic          m_ce_n = 1'b1;
    logic          m_oe_n = 1'b1;
    realtime       t_a = 0.0, t_c = 0.0, t_o = 0.0;

    always begin
        #1;
        if (fl_addr != m_addr) begin
            if (!fl_ce_n && !m_ce_n && (fl_addr[AW-1:3] == m_addr[AW-1:3]))
                t_a = $realtime + 35.0;
            else
                t_a = $realtime + 90.0;
        end
        if (!fl_ce_n && m_ce_n) t_c = $realtime + 90.0;
        if (!fl_oe_n && m_oe_n) t_o = $realtime + 20.0;
        m_addr = fl_addr;
        m_ce_n = fl_ce_n;
        m_oe_n = fl_oe_n;
        if (!fl_ce_n && !fl_oe_n && ($realtime >= t_a) && ($realtime >= t_c) && ($realtime >= t_o))
            dq = flash_word(fl_addr);
        else
            dq = flash_word(fl_addr) ^ (16'($urandom) | 16'h0001);
    end

    // Strobe monitor: high-time between bursts and output-enable containment.
    logic        mon_prev_ce = 1'b1;
    int unsigned rise_c = 0, last_gap = 0, oe_bad = 0;
    always @(negedge clk) begin
        if (fl_ce_n && !mon_prev_ce) rise_c = cyc;
        if (!fl_ce_n && mon_prev_ce) last_gap = cyc - rise_c;
        if (!fl_oe_n && fl_ce_n) oe_bad++;
        mon_prev_ce = fl_ce_n;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge showing the final word.
    task automatic run_burst(input logic [AW-1:0] addr, input logic [LW-1:0] len,
                             input int unsigned exp_cross);
        int unsigned t_prev, crosses;
        logic [AW-1:0] a;
        req_valid = 1'b1;
        req_addr  = addr;
        req_len   = len;
        while (!req_ready) @(negedge clk);
        t_prev = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!fl_ce_n && !fl_oe_n && fl_addr == addr, "R2 strobes/address", {fl_ce_n, fl_oe_n}, 0);
        crosses = 0;
        for (int i = 0; i <= int'(len); i++) begin
            while (!rd_valid) @(negedge clk);
            a = addr + AW'(i);
            if (i == 0)
                check(cyc - t_prev == FIRST_C, "R2 first latency", cyc - t_prev, FIRST_C);
            else if (a[2:0] == 3'b000) begin
                crosses++;
                check(cyc - t_prev == ACC_C, "R4 crossing latency", cyc - t_prev, ACC_C);
            end else
                check(cyc - t_prev == PAGE_C, "R3 page latency", cyc - t_prev, PAGE_C);
            check(rd_data == flash_word(a), "R5 data", rd_data, flash_word(a));
            check(rd_last == (i == int'(len)), "R6 last flag", rd_last, (i == int'(len)));
            t_prev = cyc;
            if (i < int'(len)) @(negedge clk);
        end
        check(crosses == exp_cross, "R4 crossing count", crosses, exp_cross);
        check(fl_ce_n && fl_oe_n && !req_ready, "R7 release on last", {fl_ce_n, fl_oe_n, req_ready}, 3'b110);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned lowcnt;
        repeat (3) @(negedge clk);
        check(fl_ce_n && fl_oe_n && !rd_valid && !rd_last && req_ready, "R1 reset state",
              {fl_ce_n, fl_oe_n, rd_valid, rd_last, req_ready}, 5'b11001);
        rst_n = 1'b1;
        @(negedge clk);
        check(fl_ce_n && fl_oe_n && req_ready, "R1 after release", {fl_ce_n, fl_oe_n, req_ready}, 3'b111);

        for (int v = 0; v < int'(NVEC); v++) begin
            run_burst(VEC[v][AW+LW+1:LW+2], VEC[v][LW+1:2], int'(VEC[v][1:0]));
            repeat (HIZ_C + 2) @(negedge clk);
        end

        // R9 / R7: back-to-back bursts, second request held during the guard
        run_burst(22'h000200, 4'd1, 0);
        req_valid = 1'b1;
        req_addr  = 22'h000300;
        req_len   = 4'd0;
        lowcnt = 0;
        while (!req_ready) begin
            lowcnt++;
            @(negedge clk);
        end
        check(lowcnt == HIZ_C, "R9 held-off cycles", lowcnt, HIZ_C);
        run_burst(22'h000300, 4'd0, 0);
        check(last_gap >= HIZ_C, "R7 strobe high gap", last_gap, HIZ_C);

        // R1: reset in the middle of a burst
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 22'h000400;
        req_len   = 4'd7;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(fl_ce_n && fl_oe_n && !rd_valid, "R1 mid-burst reset", {fl_ce_n, fl_oe_n, rd_valid}, 3'b110);
        rst_n = 1'b1;
        lowcnt = 0;
        repeat (40) begin
            @(negedge clk);
            if (rd_valid) lowcnt++;
        end
        check(lowcnt == 0, "R1 no words after reset", lowcnt, 0);
        run_burst(22'h000406, 4'd3, 1);
        repeat (HIZ_C + 2) @(negedge clk);

        check(oe_bad == 0, "R8 output enable inside select", oe_bad, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule